// File: doc/BRIEF.md
# Sectioned Address Mapper with Controller Interleaving

This block routes a 32-bit system address to a memory target. It holds four section descriptors, and each one is compared with the incoming address. A match picks one target: memory controller 0, memory controller 1, a pair of controllers that share a section in alternating 128-byte blocks, or a reserved space that never reaches memory. The block also returns the address as the chosen target sees it. This is the offset inside the section plus a start address for that target. For an interleaved section, bit 7 is removed from the offset, so each controller sees a dense range.

Descriptors are loaded through a simple write port. A combinational output adds up the bytes of SDRAM that the mapped, non-reserved sections describe. Boot software can use that total to size memory. The address lookup is fully combinational from the registered descriptors.

Top module: `sect_map_top`

## Requirements
- R1: Four descriptors are held in registers. When `cfg_we` is high at a rising clock edge, `cfg_wdata` is stored into descriptor `cfg_idx`. The lookup sees the new value from that edge onward.
- R2: Bits [31:24] of a descriptor give the section base, so the base address is that byte followed by 24 zero bits. An address hits the section when base <= address < base + size, with the upper bound evaluated in 33 bits.
- R3: Bits [22:20] hold a size code. The section size is 16 MB shifted left by that code, from 16 MB for code 0 up to 2 GB for code 7.
- R4: Bits [9:8] hold the map field. When it is 0 the descriptor never hits and adds nothing to `sdram_bytes`.
- R5: Bits [17:16] hold the address-space field. When it is 2 and the section is mapped, a hit reports `tgt` = 2 (reserved) with `ilv_hit` = 0, and `dev_addr` = offset + (start << 24). The section is left out of `sdram_bytes`.
- R6: When the map field is 3 (both controllers), offset bit 7 picks the target: 0 gives `tgt` = 0 and 1 gives `tgt` = 1. `ilv_hit` is 1, and `dev_addr` = {offset[31:8], offset[6:0]} + (start << 24).
- R7: When the map field is 1, the target is `tgt` = 0. When it is 2, the target is `tgt` = 1. In both cases `dev_addr` = offset + (start << 24), where start is bits [7:0] and offset = address - base.
- R8: When several descriptors hit, the one with the lowest index decides the outcome.
- R9: An address that hits no descriptor gives `miss` = 1, `hit` = 0, `tgt` = 3, `ilv_hit` = 0 and `dev_addr` = 0.
- R10: `sdram_bytes` is the 33-bit sum of the sizes of all descriptors that are mapped and not reserved, so a total of exactly 4 GB is representable.
- R11: An active reset clears every descriptor, which leaves `sdram_bytes` at 0 and makes every lookup a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_idx | input | 2 | Descriptor index to write |
| cfg_wdata | input | 32 | Descriptor value |
| req_addr | input | 32 | System address to look up |
| hit | output | 1 | Address lies in a mapped section |
| miss | output | 1 | Address lies in no mapped section |
| tgt | output | 2 | 0 controller 0, 1 controller 1, 2 reserved, 3 none |
| ilv_hit | output | 1 | Hit on an interleaved section |
| dev_addr | output | 32 | Translated address for the target |
| sdram_bytes | output | 33 | Total SDRAM bytes described by the descriptors |

## Verification
A wrong descriptor bit shows up within one cycle of the write. It appears either as a changed `sdram_bytes` or as a lookup that goes to the wrong target or returns a shifted `dev_addr`. A fault in priority selection is only visible when the address lies in two overlapping sections, so the scenarios place one address inside two sections at once. Interleave faults show up as a wrong controller or a misplaced bit. These are checked with offsets that have bit 7 set and with offsets that have it clear, and with high offset bits set.

// File: rtl/sect_map_pkg.sv
package sect_map_pkg;
  localparam int unsigned NUM_SECT  = 4;
  localparam int unsigned IDX_W     = $clog2(NUM_SECT);
  localparam int unsigned ADDR_W    = 32;
  localparam int unsigned SUM_W     = ADDR_W + 1;
  localparam int unsigned UNIT_LOG2 = 24;
  localparam logic [1:0]  SPACE_RSV = 2'd2;
  localparam logic [1:0]  MAP_NONE  = 2'd0;
  localparam logic [1:0]  MAP_BOTH  = 2'd3;

  typedef struct packed {
    logic [7:0] base;
    logic       pad_a;
    logic [2:0] size_code;
    logic [1:0] pad_b;
    logic [1:0] space;
    logic [5:0] pad_c;
    logic [1:0] map;
    logic [7:0] start;
  } sect_desc_t;

  typedef enum logic [1:0] {
    TGT_C0   = 2'd0,
    TGT_C1   = 2'd1,
    TGT_RSV  = 2'd2,
    TGT_NONE = 2'd3
  } tgt_e;
endpackage

// File: rtl/sect_desc_bank.sv
module sect_desc_bank
  import sect_map_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [IDX_W-1:0]        cfg_idx,
  input  logic [ADDR_W-1:0]       cfg_wdata,
  output sect_desc_t [NUM_SECT-1:0] desc
);
  sect_desc_t [NUM_SECT-1:0] desc_q, desc_d;

  always_comb begin
    desc_d = desc_q;
    desc_d[cfg_idx] = sect_desc_t'(cfg_wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      desc_q <= '0;
    end else if (cfg_we) begin
      desc_q <= desc_d;
    end
  end

  assign desc = desc_q;
endmodule

// File: rtl/sect_match.sv
module sect_match
  import sect_map_pkg::*;
(
  input  sect_desc_t        desc,
  input  logic [ADDR_W-1:0] addr,
  output logic              match,
  output logic [ADDR_W-1:0] offset,
  output logic [SUM_W-1:0]  size_bytes,
  output logic              counts
);
  localparam logic [SUM_W-1:0] UNIT = SUM_W'(1) << UNIT_LOG2;

  logic [SUM_W-1:0] base_w, limit_w, addr_w;

  always_comb begin
    size_bytes = UNIT << desc.size_code;
    base_w     = {1'b0, desc.base, 24'h0};
    limit_w    = base_w + size_bytes;
    addr_w     = {1'b0, addr};
    match      = (desc.map != MAP_NONE) && (addr_w >= base_w) && (addr_w < limit_w);
    offset     = addr - {desc.base, 24'h0};
    counts     = (desc.map != MAP_NONE) && (desc.space != SPACE_RSV);
  end

  always_comb begin
    AST_UNMAPPED_SILENT: assert (!(desc.map == MAP_NONE && match)); // R4
    AST_OFFSET_INSIDE: assert (!match || ({1'b0, offset} < size_bytes)); // R3
  end
endmodule

// File: rtl/sect_size_total.sv
module sect_size_total
  import sect_map_pkg::*;
(
  input  logic [NUM_SECT-1:0]            counts,
  input  logic [NUM_SECT-1:0][SUM_W-1:0] sizes,
  output logic [SUM_W-1:0]               total
);
  always_comb begin
    total = '0;
    for (int i = 0; i < NUM_SECT; i++) begin
      if (counts[i]) total = total + sizes[i];
    end
  end
endmodule

// File: rtl/sect_map_top.sv
module sect_map_top
  import sect_map_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_idx,
  input  logic [31:0] cfg_wdata,
  input  logic [31:0] req_addr,
  output logic        hit,
  output logic        miss,
  output logic [1:0]  tgt,
  output logic        ilv_hit,
  output logic [31:0] dev_addr,
  output logic [32:0] sdram_bytes
);
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  sect_desc_t [NUM_SECT-1:0]            desc;
  logic       [NUM_SECT-1:0]            match_v, count_v;
  logic       [NUM_SECT-1:0][ADDR_W-1:0] off_v;
  logic       [NUM_SECT-1:0][SUM_W-1:0] size_v;

  sect_desc_bank u_bank (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we & rst_sync_n),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .desc(desc)
  );

  for (genvar g = 0; g < NUM_SECT; g++) begin : g_sect
    sect_match u_match (
      .desc(desc[g]), .addr(req_addr), .match(match_v[g]),
      .offset(off_v[g]), .size_bytes(size_v[g]), .counts(count_v[g])
    );
  end

  sect_size_total u_total (.counts(count_v), .sizes(size_v), .total(sdram_bytes));

  logic             found;
  logic [IDX_W-1:0] sel;
  sect_desc_t       win;
  logic [ADDR_W-1:0] woff, local_off;

  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int i = 0; i < NUM_SECT; i++) begin
      if (!found && match_v[i]) begin
        found = 1'b1;
        sel   = IDX_W'(i);
      end
    end
    win  = desc[sel];
    woff = off_v[sel];
  end

  always_comb begin
    hit       = found;
    miss      = !found;
    tgt       = TGT_NONE;
    ilv_hit   = 1'b0;
    dev_addr  = '0;
    local_off = woff;
    if (found) begin
      if (win.space == SPACE_RSV) begin
        tgt = TGT_RSV;
      end else if (win.map == MAP_BOTH) begin
        ilv_hit   = 1'b1;
        tgt       = woff[7] ? TGT_C1 : TGT_C0;
        local_off = {1'b0, woff[31:8], woff[6:0]};
      end else begin
        tgt = (win.map == 2'd2) ? TGT_C1 : TGT_C0;
      end
      dev_addr = local_off + {win.start, 24'h0};
    end
  end

  AST_ILV_BLOCK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ilv_hit |-> (hit && tgt == {1'b0, req_addr[7]})); // R6
  AST_SIZE_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$past(cfg_we) |-> $stable(sdram_bytes)); // R10
  AST_MISS_CLEAN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    miss |-> (!hit && tgt == TGT_NONE && dev_addr == '0 && !ilv_hit)); // R9
  AST_RSV_FLAT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (hit && tgt == TGT_RSV) |-> !ilv_hit); // R5
endmodule

// File: tb/sect_map_top_bench.sv
module sect_map_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] req_addr = '0;
  logic        hit, miss, ilv_hit;
  logic [1:0]  tgt;
  logic [31:0] dev_addr;
  logic [32:0] sdram_bytes;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [31:0] addr;
    logic        hit;
    logic [1:0]  tgt;
    logic        ilv;
    logic [31:0] dev;
    string       tag;
  } exp_t;

  exp_t exp_q[$];

  always #2 clk = ~clk;

  sect_map_top u_sect_map_top (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .req_addr(req_addr), .hit(hit), .miss(miss),
    .tgt(tgt), .ilv_hit(ilv_hit), .dev_addr(dev_addr), .sdram_bytes(sdram_bytes)
  );

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (hit !== e.hit || miss !== !e.hit || tgt !== e.tgt ||
          ilv_hit !== e.ilv || dev_addr !== e.dev) begin
        errors++;
        $display("FAIL %s addr=%h: got hit=%b miss=%b tgt=%0d ilv=%b dev=%h, expected hit=%b tgt=%0d ilv=%b dev=%h",
                 e.tag, e.addr, hit, miss, tgt, ilv_hit, dev_addr, e.hit, e.tgt, e.ilv, e.dev);
      end
    end
  end

  task automatic write_desc(input logic [1:0] idx, input logic [31:0] val);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = val;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic lookup(input logic [31:0] a, input logic h, input logic [1:0] t,
                        input logic il, input logic [31:0] d, input string tag);
    exp_t e;
    @(posedge clk); #1;
    req_addr = a;
    e.addr = a; e.hit = h; e.tgt = t; e.ilv = il; e.dev = d; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic check_size(input logic [32:0] expv, input string tag);
    @(negedge clk);
    checks++;
    if (sdram_bytes !== expv) begin
      errors++;
      $display("FAIL %s sdram_bytes: got %h, expected %h", tag, sdram_bytes, expv);
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog R1: got no completion, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    // R11: empty after reset
    check_size(33'h0, "R11");
    lookup(32'h8000_0000, 0, 2'd3, 0, 32'h0, "R11 R9");

    // Reserved 16 MB at 0xFF in slot 0, 2 GB interleaved at 0x80 in slot 3
    write_desc(2'd0, 32'hFF02_0100);
    write_desc(2'd3, 32'h8070_0300);
    check_size(33'h0_8000_0000, "R10 R5 R1");
    lookup(32'h8000_0000, 1, 2'd0, 1, 32'h0000_0000, "R6 even block");
    lookup(32'h8000_0080, 1, 2'd1, 1, 32'h0000_0000, "R6 odd block");
    lookup(32'h8000_0105, 1, 2'd0, 1, 32'h0000_0085, "R6 compress");
    lookup(32'h8000_01C4, 1, 2'd1, 1, 32'h0000_00C4, "R6 compress odd");
    lookup(32'hFEFF_FFFF, 1, 2'd1, 1, 32'h3F7F_FFFF, "R6 high offset R3");
    lookup(32'hFF00_0010, 1, 2'd2, 0, 32'h0000_0010, "R5 R8 overlap");
    lookup(32'hFFFF_FF80, 1, 2'd2, 0, 32'h00FF_FF80, "R5 top");
    lookup(32'h7FFF_FFFF, 0, 2'd3, 0, 32'h0, "R9 R2 below base");

    // Slot 1: 16 MB on controller 1 at 0xFE, start 0x40, overlaps slot 3
    write_desc(2'd1, 32'hFE00_0240);
    check_size(33'h0_8100_0000, "R10");
    lookup(32'hFE00_0010, 1, 2'd1, 0, 32'h4000_0010, "R8 R7");

    // Slot 2: unmapped entry
    write_desc(2'd2, 32'h1000_0000);
    check_size(33'h0_8100_0000, "R4 size");
    lookup(32'h1000_0000, 0, 2'd3, 0, 32'h0, "R4 no hit");

    // Slot 2: 512 MB on controller 0 at 0x10, start 0x01
    write_desc(2'd2, 32'h1050_0101);
    check_size(33'h0_A100_0000, "R3 R10");
    lookup(32'h1000_0000, 1, 2'd0, 0, 32'h0100_0000, "R7 R2 base");
    lookup(32'h2FFF_FFFF, 1, 2'd0, 0, 32'h20FF_FFFF, "R3 last byte");
    lookup(32'h3000_0000, 0, 2'd3, 0, 32'h0, "R3 R9 past end");

    // Full 4 GB: two 2 GB sections, one unmapped, one reserved
    write_desc(2'd0, 32'h0070_0100);
    write_desc(2'd1, 32'h8070_0200);
    write_desc(2'd2, 32'h0000_0000);
    write_desc(2'd3, 32'hFF02_0100);
    check_size(33'h1_0000_0000, "R10 4GB");
    lookup(32'h0000_0000, 1, 2'd0, 0, 32'h0000_0000, "R7 c0");
    lookup(32'h7FFF_FFFF, 1, 2'd0, 0, 32'h7FFF_FFFF, "R7 c0 end");
    lookup(32'hFFFF_FFFF, 1, 2'd1, 0, 32'h7FFF_FFFF, "R8 R7 c1");

    // R11: reset in the middle of operation
    @(posedge clk); #1 rst_n = 1'b0;
    check_size(33'h0, "R11 mid");
    lookup(32'h0000_0000, 0, 2'd3, 0, 32'h0, "R11 mid miss");
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule